// File: doc/BRIEF.md
# Button Press and Release Debouncer

This block cleans up the signal from one mechanical push button that pulls its pin to ground when pressed. A pull-up holds the pin high while the button is released. The raw pin first passes through a synchronizer chain. After that, a four-state machine looks at it only on cycles where a periodic tick enable is high, which is normally once per millisecond. The machine has four phases: released and stable, qualifying a press, held and stable, and qualifying a release.

A press counts only after the low level has been seen on a run of consecutive ticks. A release needs the same run of high samples. One sample of the opposite level during a qualification phase drops the machine back to the stable phase it came from, and no event is produced. The block has two one-clock event pulses, one for press and one for release, and a debounced level. Downstream logic can use either the pulses or the level.

Top module: `btn_debounce`

## Requirements
- R1: While reset is held, and after it is released, the machine is in the released-stable phase with its counter at zero. `pressed_level`, `press_pulse` and `release_pulse` are all 0.
- R2: The input is active low: 0 on `btn_n_raw` means pressed and 1 means released. A pin held at 1 never produces a press event.
- R3: From released-stable, the first low tick sample enters press qualification. After that, QUAL_TICKS more consecutive low tick samples are needed (default 20, so 21 in total). On the last of them the block emits a press event and `pressed_level` becomes 1.
- R4: During press qualification, a single high tick sample returns the machine to released-stable with no event. The run count is discarded, so a later press must again meet the full R3 count.
- R5: From held, the first high tick sample enters release qualification. After that, QUAL_TICKS more consecutive high tick samples give a release event and `pressed_level` becomes 0.
- R6: During release qualification, a single low tick sample returns the machine to held with no event, and `pressed_level` stays 1.
- R7: Each event pulse is exactly one clock wide. It is asserted only in the clock that follows a clock edge where `tick_en` was 1. Press and release pulses never overlap.
- R8: On clock edges where `tick_en` is 0, the phase and the counter do not change, whatever the pin does.
- R9: `pressed_level` is 1 in the held and release-qualifying phases, and 0 in the other two.
- R10: The pin reaches the machine through SYNC_STAGES flip-flops (default 2). A low level that appears on the pin only in the clock of the tick edge is not seen by that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-clock sampling strobe (nominally 1 ms) |
| btn_n_raw | input | 1 | Asynchronous button pin, low when pressed |
| press_pulse | output | 1 | One-clock pulse on a qualified press |
| release_pulse | output | 1 | One-clock pulse on a qualified release |
| pressed_level | output | 1 | Debounced button state, 1 = pressed |

## Verification
Two situations are hard to reach from the ports. The first is a run that ends exactly one sample short of the threshold. The second is a cancel followed by a new run whose first sample falls in the same tick that ends the bounce. The stimulus table builds both from runs of chosen length: 20 lows and then a high, and three alternating single ticks followed by exactly 20 lows. The synchronizer depth is only visible if the pin changes in the same clock as the tick. A directed test therefore drops the pin for that single clock over many ticks and expects no press at all.

// File: rtl/btn_debounce_pkg.sv
package btn_debounce_pkg;

    typedef enum logic [1:0] {
        PH_RELEASED = 2'd0,
        PH_PRESS_QUAL = 2'd1,
        PH_HELD = 2'd2,
        PH_REL_QUAL = 2'd3
    } dbc_phase_e;

    typedef struct packed {
        logic press;
        logic release_ev;
    } dbc_evt_t;

    typedef struct packed {
        logic clr;
        logic inc;
    } dbc_cnt_ctl_t;

    function automatic logic phase_is_down(input dbc_phase_e ph);
        return (ph == PH_HELD) || (ph == PH_REL_QUAL);
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RESET_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/btn_qual_cnt.sv
module btn_qual_cnt
    import btn_debounce_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 20,
    localparam int unsigned CW = cnt_width(QUAL_TICKS)
) (
    input  logic         clk,
    input  logic         rst,
    input  dbc_cnt_ctl_t ctl,
    output logic         last_step
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (ctl.clr) cnt <= '0;
        else if (ctl.inc) cnt <= cnt + 1'b1;
    end

    assign last_step = (cnt == CW'(QUAL_TICKS - 1));

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(QUAL_TICKS));

    a_r8_cnt_still: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.inc) |=> $stable(cnt));
endmodule

// File: rtl/btn_phase_fsm.sv
module btn_phase_fsm
    import btn_debounce_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         pin_n,
    input  logic         last_step,
    output dbc_cnt_ctl_t cnt_ctl,
    output dbc_evt_t     evt,
    output logic         down
);
    dbc_phase_e phase, phase_nx;
    dbc_evt_t   evt_nx;

    always_comb begin
        phase_nx = phase;
        evt_nx   = '0;
        cnt_ctl  = '0;
        if (tick_en) begin
            unique case (phase)
                PH_RELEASED: begin
                    if (!pin_n) begin
                        phase_nx    = PH_PRESS_QUAL;
                        cnt_ctl.clr = 1'b1;
                    end
                end
                PH_PRESS_QUAL: begin
                    if (!pin_n) begin
                        cnt_ctl.inc = 1'b1;
                        if (last_step) begin
                            phase_nx     = PH_HELD;
                            evt_nx.press = 1'b1;
                        end
                    end else begin
                        phase_nx = PH_RELEASED;
                    end
                end
                PH_HELD: begin
                    if (pin_n) begin
                        phase_nx    = PH_REL_QUAL;
                        cnt_ctl.clr = 1'b1;
                    end
                end
                PH_REL_QUAL: begin
                    if (pin_n) begin
                        cnt_ctl.inc = 1'b1;
                        if (last_step) begin
                            phase_nx          = PH_RELEASED;
                            evt_nx.release_ev = 1'b1;
                        end
                    end else begin
                        phase_nx = PH_HELD;
                    end
                end
                default: phase_nx = PH_RELEASED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RELEASED;
            evt   <= '0;
        end else begin
            phase <= phase_nx;
            evt   <= evt_nx;
        end
    end

    assign down = phase_is_down(phase);

    a_r7_evt_after_tick: assert property (@(posedge clk) disable iff (rst)
        (evt.press || evt.release_ev) |-> $past(tick_en));

    a_r7_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt.press && evt.release_ev));

    a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(phase));

    a_r3_press_lands_held: assert property (@(posedge clk) disable iff (rst)
        evt.press |-> (phase == PH_HELD));

    a_r5_release_lands_idle: assert property (@(posedge clk) disable iff (rst)
        evt.release_ev |-> (phase == PH_RELEASED));

    a_r9_level_rise_has_press: assert property (@(posedge clk) disable iff (rst)
        $rose(down) |-> evt.press);
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce
    import btn_debounce_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic btn_n_raw,
    output logic press_pulse,
    output logic release_pulse,
    output logic pressed_level
);
    logic         pin_n_s;
    logic         last_step;
    dbc_cnt_ctl_t cnt_ctl;
    dbc_evt_t     evt;

    btn_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(btn_n_raw),
        .q_sync (pin_n_s)
    );

    btn_qual_cnt #(.QUAL_TICKS(QUAL_TICKS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl      (cnt_ctl),
        .last_step(last_step)
    );

    btn_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .pin_n    (pin_n_s),
        .last_step(last_step),
        .cnt_ctl  (cnt_ctl),
        .evt      (evt),
        .down     (pressed_level)
    );

    assign press_pulse   = evt.press;
    assign release_pulse = evt.release_ev;

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!press_pulse && !release_pulse && !pressed_level));
endmodule

// File: tb/sim_btn_debounce.sv
module sim_btn_debounce;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic btn_n_raw = 1'b1;
    logic press_pulse, release_pulse, pressed_level;

    int errors = 0;
    int checks = 0;
    int n_press = 0;
    int n_rel = 0;
    logic tick_q = 1'b0;
    logic press_prev = 1'b0;
    logic rel_prev = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_debounce u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .btn_n_raw(btn_n_raw),
        .press_pulse(press_pulse), .release_pulse(release_pulse),
        .pressed_level(pressed_level)
    );

    // entry: {pin level, ticks, cumulative presses, cumulative releases, level}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 8'd5,  4'd0, 4'd0, 1'b0},
        {1'b0, 8'd20, 4'd0, 4'd0, 1'b0},
        {1'b1, 8'd1,  4'd0, 4'd0, 1'b0},
        {1'b0, 8'd21, 4'd1, 4'd0, 1'b1},
        {1'b0, 8'd10, 4'd1, 4'd0, 1'b1},
        {1'b1, 8'd20, 4'd1, 4'd0, 1'b1},
        {1'b0, 8'd1,  4'd1, 4'd0, 1'b1},
        {1'b1, 8'd21, 4'd1, 4'd1, 1'b0},
        {1'b0, 8'd3,  4'd1, 4'd1, 1'b0},
        {1'b1, 8'd2,  4'd1, 4'd1, 1'b0},
        {1'b0, 8'd25, 4'd2, 4'd1, 1'b1},
        {1'b1, 8'd21, 4'd2, 4'd2, 1'b0},
        {1'b0, 8'd1,  4'd2, 4'd2, 1'b0},
        {1'b1, 8'd1,  4'd2, 4'd2, 1'b0},
        {1'b0, 8'd1,  4'd2, 4'd2, 1'b0},
        {1'b0, 8'd20, 4'd3, 4'd2, 1'b1},
        {1'b1, 8'd21, 4'd3, 4'd3, 1'b0}
    };

    always @(posedge clk) tick_q <= tick_en;

    // R7 monitor: pulses one clock wide, only after a tick edge
    always @(negedge clk) begin
        if (press_pulse || release_pulse) begin
            checks++;
            if ((press_pulse && press_prev) || (release_pulse && rel_prev) ||
                !tick_q || (press_pulse && release_pulse)) begin
                errors++;
                $display("FAIL R7 pulse shape: press=%0b release=%0b tick_q=%0b expected single pulse after tick",
                         press_pulse, release_pulse, tick_q);
            end
        end
        if (press_pulse) n_press++;
        if (release_pulse) n_rel++;
        press_prev = press_pulse;
        rel_prev = release_pulse;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic lvl, input int n);
        @(negedge clk) btn_n_raw = lvl;
        for (int i = 0; i < n; i++) begin
            repeat (3) @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 level in reset", int'(pressed_level), 0);
        check("R1 press in reset", int'(press_pulse), 0);
        check("R1 release in reset", int'(release_pulse), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 level after reset", int'(pressed_level), 0);

        // R2 R3 R4 R5 R6 R9 stimulus table
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][17], int'(VEC[v][16:9]));
            check($sformatf("R3/R4 presses after vec %0d", v), n_press, int'(VEC[v][8:5]));
            check($sformatf("R5/R6 releases after vec %0d", v), n_rel, int'(VEC[v][4:1]));
            check($sformatf("R9 level after vec %0d", v), int'(pressed_level), int'(VEC[v][0]));
        end

        // R8: pin low with no ticks does nothing
        @(negedge clk) btn_n_raw = 1'b0;
        repeat (120) @(negedge clk);
        check("R8 no tick level", int'(pressed_level), 0);
        check("R8 no tick presses", n_press, 3);
        // one tick after idle gap: only enters qualification, no press
        apply(1'b0, 1);
        check("R8 single tick no press", n_press, 3);
        apply(1'b1, 1);

        // R10: low only in the tick clock is never seen
        for (int i = 0; i < 25; i++) begin
            repeat (3) @(negedge clk);
            btn_n_raw = 1'b0;
            tick_en = 1'b1;
            @(negedge clk);
            btn_n_raw = 1'b1;
            tick_en = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R10 late pin change unseen", n_press, 3);
        check("R10 level", int'(pressed_level), 0);

        // R2: long high run never presses
        apply(1'b1, 30);
        check("R2 high pin no press", n_press, 3);

        // R1: reset from held
        apply(1'b0, 21);
        check("R3 press before reset", n_press, 4);
        check("R9 level before reset", int'(pressed_level), 1);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset clears level", int'(pressed_level), 0);
        @(negedge clk) rst = 1'b0;
        // counter restarts: 20 lows not enough
        apply(1'b0, 20);
        check("R1 counter cleared by reset", n_press, 4);
        check("R1 level still released", int'(pressed_level), 0);
        apply(1'b0, 1);
        check("R3 press at threshold after reset", n_press, 5);
        check("R5 no spurious release", n_rel, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule